// File: doc/BRIEF.md
# Tri-State PWM Gate Sequencer

This block turns a three-level PWM command into the two gate commands of a synchronous buck half-bridge. The command arrives already decoded into a 2-bit level: low, high or mid. On every clock edge the block registers a high-gate command and a low-gate command. Low turns the low gate on and high turns the high gate on. Mid is a request to park the bridge, with both switches off, but only once it has lasted for a programmable number of clock edges. A shorter mid glitch leaves the last real command in force.

Three qualifiers shape the result. A low-gate enable removes the low gate without touching the high gate. A power-good input keeps both gates off while it is deasserted. A high-gate inhibit from the fault logic blocks the high gate while the low gate keeps its normal behaviour. Break-before-make timing, counted in clock cycles, guarantees that the two gates never overlap. Both outputs are registered, so a change at the inputs sampled on one edge appears on the outputs right after that edge.

Top module: `tristate_gate_sequencer`

## Requirements
- R1: With a powered, uninhibited bridge, a level of 2'b01 (high) drives gateHigh to 1 and gateLow to 0 once dead time allows.
- R2: A level of 2'b00 (low) with lowGateEn at 1 drives gateLow to 1 and gateHigh to 0 once dead time allows.
- R3: While lowGateEn is 0, gateLow is 0 after every edge, and gateHigh behaves as it would with lowGateEn at 1.
- R4: When a mid level (2'b10 or 2'b11) has been sampled on HOLD_CYC consecutive edges, both gates are 0 after that edge, whatever lowGateEn is. They stay 0 while mid continues.
- R5: A mid run shorter than HOLD_CYC edges keeps the last low/high command in force, still subject to R3, R7, R8 and R9.
- R6: On the first edge that samples low or high after a shutdown caused by R4, the gates follow the new level with no extra delay beyond R9.
- R7: Whenever powerGood is 0 at an edge, both gates are 0 after that edge.
- R8: Whenever highInhibit is 1 at an edge, gateHigh is 0 after that edge, and gateLow follows its usual rules.
- R9: gateHigh and gateLow are never 1 together. A gate may become 1 at an edge only if the other gate was 0 after each of the DEAD_CYC preceding edges since reset, counting the one just before this edge. Turning a gate off takes effect at once.
- R10: While rstN is 0 at an edge, both gates are 0 after it and all history (mid run, held command, dead-time runs) restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pwmLevel | input | 2 | Decoded PWM level: 00 low, 01 high, 10 and 11 mid |
| lowGateEn | input | 1 | 1 lets the low gate follow PWM, 0 keeps it off |
| powerGood | input | 1 | Supplies qualified; 0 keeps both gates off |
| highInhibit | input | 1 | Fault inhibit; 1 forces the high gate off |
| gateHigh | output | 1 | High-side gate command |
| gateLow | output | 1 | Low-side gate command |

## Verification
A corrupted mid-run counter shows at the gates one edge after it matters. The bridge shuts down either one edge early or one edge late, or a short glitch wrongly parks it. Stimulus therefore holds mid for runs both just below and exactly at the hold-off length. A stale held command shows as the wrong gate during the first mid edges. A wrong dead-time counter shows as a gate rising an edge too early or too late after the other falls. Every edge is compared against a cycle model, so any such error is caught on the first edge where the outputs diverge.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [1:0] {
    LVL_LOW     = 2'b00,
    LVL_HIGH    = 2'b01,
    LVL_MID     = 2'b10,
    LVL_MID_ALT = 2'b11
  } pwmLevel_e;

  // strobes from control to the gate datapath
  typedef struct packed {
    logic driveHigh;
    logic driveLow;
  } gateReq_t;

  localparam int NUM_GATES = 2;
  localparam int GATE_LOW  = 0;
  localparam int GATE_HIGH = 1;

endpackage

// File: rtl/gseq_ctrl.sv
module gseq_ctrl
  import gseq_pkg::*;
#(
  parameter int HOLD_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmLevel,
  input  logic       lowGateEn,
  input  logic       powerGood,
  input  logic       highInhibit,
  output gateReq_t   req
);

  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_SAT  = HW'(HOLD_CYC);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] midRun;
  logic          heldHigh;
  logic          isMid;
  logic          midExpired;
  logic          cmdHigh;

  always_comb begin
    isMid      = pwmLevel[1];
    midExpired = isMid && (midRun >= HOLD_LAST);
    cmdHigh    = isMid ? heldHigh : (pwmLevel_e'(pwmLevel) == LVL_HIGH);
    req.driveHigh = powerGood && !midExpired && cmdHigh && !highInhibit;
    req.driveLow  = powerGood && !midExpired && !cmdHigh && lowGateEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midRun   <= '0;
      heldHigh <= 1'b0;
    end else if (isMid) begin
      midRun <= (midRun == HOLD_SAT) ? midRun : midRun + 1'b1;
    end else begin
      midRun   <= '0;
      heldHigh <= cmdHigh;
    end
  end

endmodule

// File: rtl/gseq_lane.sv
module gseq_lane #(
  parameter int DEAD_CYC = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic want,
  input  logic otherOn,
  output logic gateOn
);

  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_SAT  = CW'(DEAD_CYC);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);

  logic [CW-1:0] otherOffRun;
  logic          mayRise;

  assign mayRise = !otherOn && (otherOffRun >= DEAD_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      otherOffRun <= '0;
      gateOn      <= 1'b0;
    end else begin
      otherOffRun <= otherOn ? '0 :
                     ((otherOffRun == DEAD_SAT) ? otherOffRun : otherOffRun + 1'b1);
      gateOn      <= want && (gateOn || mayRise);
    end
  end

endmodule

// File: rtl/gseq_datapath.sv
module gseq_datapath
  import gseq_pkg::*;
#(
  parameter int DEAD_CYC = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  gateReq_t req,
  output logic     gateHigh,
  output logic     gateLow
);

  logic [NUM_GATES-1:0] wantVec;
  logic [NUM_GATES-1:0] gateVec;

  assign wantVec[GATE_HIGH] = req.driveHigh;
  assign wantVec[GATE_LOW]  = req.driveLow;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_lane
    gseq_lane #(.DEAD_CYC(DEAD_CYC)) i_lane (
      .clk    (clk),
      .rstN   (rstN),
      .want   (wantVec[g]),
      .otherOn(gateVec[NUM_GATES-1-g]),
      .gateOn (gateVec[g])
    );
  end

  assign gateHigh = gateVec[GATE_HIGH];
  assign gateLow  = gateVec[GATE_LOW];

endmodule

// File: rtl/tristate_gate_sequencer.sv
module tristate_gate_sequencer
  import gseq_pkg::*;
#(
  parameter int HOLD_CYC = 3,
  parameter int DEAD_CYC = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmLevel,
  input  logic       lowGateEn,
  input  logic       powerGood,
  input  logic       highInhibit,
  output logic       gateHigh,
  output logic       gateLow
);

  gateReq_t req;

  gseq_ctrl #(.HOLD_CYC(HOLD_CYC)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwmLevel   (pwmLevel),
    .lowGateEn  (lowGateEn),
    .powerGood  (powerGood),
    .highInhibit(highInhibit),
    .req        (req)
  );

  gseq_datapath #(.DEAD_CYC(DEAD_CYC)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .req     (req),
    .gateHigh(gateHigh),
    .gateLow (gateLow)
  );

endmodule

// File: rtl/gseq_checker.sv
module gseq_checker #(
  parameter int HOLD_CYC = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwmLevel,
  input logic       lowGateEn,
  input logic       powerGood,
  input logic       highInhibit,
  input logic       gateHigh,
  input logic       gateLow
);

  int unsigned midSeen;

  always_ff @(posedge clk) begin
    if (!rstN) midSeen <= 0;
    else if (pwmLevel[1]) midSeen <= (midSeen >= HOLD_CYC) ? midSeen : midSeen + 1;
    else midSeen <= 0;
  end

  // R9
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHigh && gateLow));

  a_r9_high_after_low_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHigh) |-> $past(!gateLow));

  a_r9_low_after_high_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLow) |-> $past(!gateHigh));

  a_r3_low_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !lowGateEn |=> !gateLow);

  a_r7_power_not_good: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> (!gateHigh && !gateLow));

  a_r8_high_inhibited: assert property (@(posedge clk) disable iff (!rstN)
    highInhibit |=> !gateHigh);

  a_r4_mid_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    (pwmLevel[1] && (midSeen + 1 >= HOLD_CYC)) |=> (!gateHigh && !gateLow));

endmodule

bind tristate_gate_sequencer gseq_checker #(.HOLD_CYC(HOLD_CYC)) i_gseq_checker (
  .clk        (clk),
  .rstN       (rstN),
  .pwmLevel   (pwmLevel),
  .lowGateEn  (lowGateEn),
  .powerGood  (powerGood),
  .highInhibit(highInhibit),
  .gateHigh   (gateHigh),
  .gateLow    (gateLow)
);

// File: tb/test_tristate_gate_sequencer.sv
module test_tristate_gate_sequencer;

  localparam int HOLD = 3;
  localparam int DT   = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] pwmLevel;
  logic       lowGateEn, powerGood, highInhibit;
  logic       gateHigh, gateLow;

  always #5 clk = ~clk;

  tristate_gate_sequencer #(.HOLD_CYC(HOLD), .DEAD_CYC(DT)) i_tristate_gate_sequencer (
    .clk(clk), .rstN(rstN), .pwmLevel(pwmLevel), .lowGateEn(lowGateEn),
    .powerGood(powerGood), .highInhibit(highInhibit),
    .gateHigh(gateHigh), .gateLow(gateLow)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // cycle model state, built from the requirements
  int mMidRun, mOffH, mOffL;
  bit mLastH, mGh, mGl;

  function automatic int satInc(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  task automatic checkGates(string tag, bit expH, bit expL);
    total++;
    if (gateHigh !== expH || gateLow !== expL) begin
      bad++;
      $display("FAIL %s: actual gh=%b gl=%b expected gh=%b gl=%b at %0t",
               tag, gateHigh, gateLow, expH, expL, $time);
    end
  endtask

  task automatic clearModel();
    mMidRun = 0; mOffH = 0; mOffL = 0;
    mLastH = 0; mGh = 0; mGl = 0;
  endtask

  // R10: reset dominates whatever the inputs say
  task automatic doReset(int cycles);
    rstN = 1'b0;
    pwmLevel = 2'b01; lowGateEn = 1'b1; powerGood = 1'b1; highInhibit = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      checkGates("R10 reset", 1'b0, 1'b0);
    end
    clearModel();
    rstN = 1'b1;
  endtask

  // called right after a negedge; applies inputs, predicts, checks after the edge
  task automatic step(input logic [1:0] lvl, input bit lg, input bit pg, input bit inh);
    bit isMid, shut, cmdH, wH, wL, nGh, nGl;
    string tag;
    pwmLevel = lvl; lowGateEn = lg; powerGood = pg; highInhibit = inh;
    isMid = lvl[1];
    shut  = isMid && (mMidRun + 1 >= HOLD);
    cmdH  = isMid ? mLastH : (lvl == 2'b01);
    wH    = pg && !shut && cmdH && !inh;
    wL    = pg && !shut && !cmdH && lg;
    nGh   = wH && (mGh || (!mGl && mOffL + 1 >= DT));
    nGl   = wL && (mGl || (!mGh && mOffH + 1 >= DT));
    if (!pg)                               tag = "R7 power not good";
    else if (shut)                         tag = "R4 mid hold-off shutdown";
    else if (isMid)                        tag = "R5 short mid keeps command";
    else if (mMidRun >= HOLD)              tag = "R6 resume after mid";
    else if ((wH && !nGh) || (wL && !nGl)) tag = "R9 dead time";
    else if (inh && cmdH)                  tag = "R8 high inhibit";
    else if (!lg && !cmdH)                 tag = "R3 low gate disabled";
    else if (cmdH)                         tag = "R1 high level";
    else                                   tag = "R2 low level";
    @(posedge clk); @(negedge clk);
    mOffL   = mGl ? 0 : satInc(mOffL, DT);
    mOffH   = mGh ? 0 : satInc(mOffH, DT);
    mMidRun = isMid ? satInc(mMidRun, HOLD) : 0;
    if (!isMid) mLastH = cmdH;
    mGh = nGh; mGl = nGl;
    checkGates(tag, mGh, mGl);
  endtask

  task automatic repeatStep(int n, logic [1:0] lvl, bit lg, bit pg, bit inh);
    for (int i = 0; i < n; i++) step(lvl, lg, pg, inh);
  endtask

  initial begin
    void'($urandom(32'h1357_2468));
    @(negedge clk);
    doReset(3);
    // R2 then R1 with dead-time transitions (R9)
    repeatStep(4, 2'b00, 1, 1, 0);
    repeatStep(4, 2'b01, 1, 1, 0);
    repeatStep(4, 2'b00, 1, 1, 0);
    // R5 short mid from low, then from high
    repeatStep(HOLD - 1, 2'b10, 1, 1, 0);
    repeatStep(3, 2'b00, 1, 1, 0);
    repeatStep(3, 2'b01, 1, 1, 0);
    repeatStep(HOLD - 1, 2'b11, 1, 1, 0);
    repeatStep(2, 2'b01, 1, 1, 0);
    // R4 full mid shutdown with 10 and 11, lowGateEn both ways, then R6
    repeatStep(HOLD + 2, 2'b10, 1, 1, 0);
    step(2'b01, 1, 1, 0);
    repeatStep(HOLD + 1, 2'b11, 0, 1, 0);
    repeatStep(3, 2'b00, 1, 1, 0);
    // R3 low gate disabled, high unaffected
    repeatStep(3, 2'b00, 0, 1, 0);
    repeatStep(3, 2'b01, 0, 1, 0);
    // R8 inhibit: high blocked, low still normal
    repeatStep(3, 2'b01, 1, 1, 1);
    repeatStep(3, 2'b00, 1, 1, 1);
    // R7 power not good
    repeatStep(3, 2'b01, 1, 0, 0);
    repeatStep(3, 2'b00, 1, 0, 0);
    // constrained random: levels held for short runs around the hold-off
    for (int i = 0; i < 1500; i++) begin
      logic [1:0] lvl;
      int run;
      bit lg, pg, inh;
      lvl = 2'($urandom % 4);
      run = 1 + int'($urandom % (HOLD + 3));
      lg  = ($urandom % 8) != 0;
      pg  = ($urandom % 16) != 0;
      inh = ($urandom % 8) == 0;
      repeatStep(run, lvl, lg, pg, inh);
    end
    // reset in the middle of operation
    repeatStep(3, 2'b01, 1, 1, 0);
    doReset(2);
    repeatStep(4, 2'b00, 1, 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule